// File: doc/BRIEF.md
# Electronic Shutter Setting Register

This block holds the electronic shutter configuration of an image sensor timing generator and turns it into three values that the exposure logic downstream consumes: a shutter mode (off, flickerless, high-speed or low-speed), an exposure length in lines and an exposure length in frames. Exposure counting itself happens elsewhere.

The configuration has two sources, and one input pin picks between them. In serial mode, a 12-bit word is clocked in on a data/clock pair and then committed by a strobe. In parallel mode, the two mode pins choose the mode directly. The same three serial pins, now read as static levels, form a 3-bit code that indexes a fixed speed table. That table gives a line count for the high-speed mode and a frame count for the low-speed mode.

All pins are sampled in the block's own clock domain. The serial clock and the strobe are edge-detected there, so each high or low level on them must last at least one clock period. The decoded outputs are registered.

Top module: `shutter_setting_reg`

## Requirements
- R1: After reset is released in serial mode, the outputs read mode OFF (encoding 0), 525 lines and 1 frame.
- R2: In serial mode, each rising edge of the serial clock shifts in one data bit. The first bit shifted is mode bit 1, then mode bit 0, then value bits 9 down to 0. A rising edge of the strobe commits the last 12 bits, and the outputs show the committed word within 3 clock cycles of that edge.
- R3: The mode bits decode as follows, with mode encodings OFF=0, FLICKERLESS=1, HIGH=2, LOW=3. (1,1) gives OFF, 525 lines, 1 frame. (0,1) gives HIGH, lines equal to the 10-bit value, 1 frame. (1,0) gives LOW, 525 lines, frames equal to the value. (0,0) gives FLICKERLESS, 315 lines, 1 frame.
- R4: A strobe rising edge with no serial clock edge since the previous commit (or since reset) leaves the outputs unchanged.
- R5: When more than 12 serial clock edges precede a strobe, only the last 12 bits are kept.
- R6: In serial mode, the mode pins have no effect on the outputs.
- R7: In parallel mode, mode pins (1,1) give OFF/525/1 and mode pins (0,0) give FLICKERLESS/315/1.
- R8: In parallel mode with mode pins (0,1), the speed code is {data, clock, strobe}, with data as the most significant bit. The mode is HIGH, frames is 1, and lines are 262, 126, 63, 31, 15, 7, 3, 1 for codes 7 down to 0. These counts are floor(15750 / d) for exposures of 1/d seconds, with d running 60, 125, 250, 500, 1000, 2000, 4000, 10000.
- R9: In parallel mode with mode pins (1,0), the mode is LOW, lines is 525, and frames = 9 − code. Code 7 therefore gives 2 frames and code 0 gives 9.
- R10: Serial pin activity while in parallel mode does not change the stored serial word. The word in force before parallel mode reappears when serial mode is selected again.
- R11: Asserting reset clears a previously committed serial word back to the R1 values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_parallel | input | 1 | 0: serial loading, 1: parallel pin decoding |
| ser_clk | input | 1 | Serial bit clock; level bit 1 of the speed code in parallel mode |
| ser_data | input | 1 | Serial data; level bit 2 of the speed code in parallel mode |
| ser_strobe | input | 1 | Serial commit strobe; level bit 0 of the speed code in parallel mode |
| mode_pins | input | 2 | Parallel mode selection: [1] is mode bit 1, [0] is mode bit 0 |
| exp_mode | output | 2 | Decoded shutter mode |
| exp_lines | output | 10 | Exposure length in lines |
| exp_frames | output | 10 | Exposure length in frames |

## Verification
The hardest state to reach is the stored serial word surviving a stretch of parallel operation. In that stretch the serial pins toggle as table codes, with clock-like and strobe-like edges, and that must not disturb the held word. The bench loads a distinctive high-speed word and then walks every parallel code in both counting modes, which produces many such edges. It returns the pins to low before leaving parallel mode and then expects the old word back. Overlong shift sequences and a strobe with no preceding clock edges are also driven on purpose, to show the word keeps only the last 12 bits and is left alone when no bits have arrived.

// File: rtl/shutter_cfg_pkg.sv
package shutter_cfg_pkg;

  typedef enum logic [1:0] {
    SHUT_OFF     = 2'd0,
    SHUT_FLICKER = 2'd1,
    SHUT_HIGH    = 2'd2,
    SHUT_LOW     = 2'd3
  } shut_mode_e;

  // Exposure denominator (1/d seconds) selected by a parallel speed code.
  function automatic int speed_den(input int code);
    case (code)
      0:       speed_den = 10000;
      1:       speed_den = 4000;
      2:       speed_den = 2000;
      3:       speed_den = 1000;
      4:       speed_den = 500;
      5:       speed_den = 250;
      6:       speed_den = 125;
      default: speed_den = 60;
    endcase
  endfunction

  // Mode bit pair to shutter mode.
  function automatic shut_mode_e decode_mode(input logic [1:0] mb);
    case (mb)
      2'b11:   decode_mode = SHUT_OFF;
      2'b01:   decode_mode = SHUT_HIGH;
      2'b10:   decode_mode = SHUT_LOW;
      default: decode_mode = SHUT_FLICKER;
    endcase
  endfunction

endpackage

// File: rtl/shutter_serial_loader.sv
module shutter_serial_loader #(
  parameter int WORD_W = 12,
  parameter logic [WORD_W-1:0] RESET_WORD = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              ser_strobe,
  output logic [WORD_W-1:0] word_o,
  output logic              commit_o
);

  logic              clk_q, stb_q;
  logic              clk_rise, stb_rise;
  logic [WORD_W-1:0] shift_q, shift_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic              have_q, have_d;
  logic              commit;

  assign clk_rise = ser_clk & ~clk_q;
  assign stb_rise = ser_strobe & ~stb_q;
  assign commit   = enable & stb_rise & have_q;

  always_comb begin
    shift_d = shift_q;
    word_d  = word_q;
    have_d  = have_q;
    if (enable) begin
      if (stb_rise) begin
        if (have_q) begin
          word_d = shift_q;
          have_d = 1'b0;
        end
      end else if (clk_rise) begin
        shift_d = {shift_q[WORD_W-2:0], ser_data};
        have_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_q   <= 1'b0;
      stb_q   <= 1'b0;
      shift_q <= '0;
      word_q  <= RESET_WORD;
      have_q  <= 1'b0;
    end else begin
      clk_q   <= ser_clk;
      stb_q   <= ser_strobe;
      shift_q <= shift_d;
      word_q  <= word_d;
      have_q  <= have_d;
    end
  end

  assign word_o   = word_q;
  assign commit_o = commit;

  // R4: strobe without any shifted bit keeps the held word
  p_nobits_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && stb_rise && !have_q) |=> $stable(word_q));

  // R10: loader frozen while disabled
  p_disabled_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable) |=> ($stable(word_q) && $stable(shift_q)));

  // R2: a commit consumes the shifted bits
  p_commit_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !have_q);

endmodule

// File: rtl/shutter_speed_table.sv
module shutter_speed_table #(
  parameter int VAL_W           = 10,
  parameter int CODE_W          = 3,
  parameter int LINES_PER_FRAME = 525,
  parameter int FRAME_RATE      = 30,
  parameter int MIN_FRAMES      = 2
) (
  input  logic [CODE_W-1:0] code,
  output logic [VAL_W-1:0]  lines_o,
  output logic [VAL_W-1:0]  frames_o
);
  import shutter_cfg_pkg::*;

  localparam int NCODES        = 1 << CODE_W;
  localparam int LINES_PER_SEC = LINES_PER_FRAME * FRAME_RATE;

  logic [VAL_W-1:0] line_tab  [NCODES];
  logic [VAL_W-1:0] frame_tab [NCODES];

  for (genvar c = 0; c < NCODES; c++) begin : g_code
    localparam int DEN = speed_den(c);
    assign line_tab[c]  = VAL_W'(LINES_PER_SEC / DEN);
    assign frame_tab[c] = VAL_W'(MIN_FRAMES + NCODES - 1 - c);
  end

  assign lines_o  = line_tab[code];
  assign frames_o = frame_tab[code];

  // R9: frame table output within its range
  always_comb begin
    p_frames_range_r9: assert (frames_o >= VAL_W'(MIN_FRAMES) &&
                               frames_o <= VAL_W'(MIN_FRAMES + NCODES - 1));
  end

endmodule

// File: rtl/shutter_setting_reg.sv
module shutter_setting_reg #(
  parameter int VAL_W           = 10,
  parameter int LINES_PER_FRAME = 525,
  parameter int FRAME_RATE      = 30,
  parameter int FLICKER_HZ      = 50
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_parallel,
  input  logic             ser_clk,
  input  logic             ser_data,
  input  logic             ser_strobe,
  input  logic [1:0]       mode_pins,
  output logic [1:0]       exp_mode,
  output logic [VAL_W-1:0] exp_lines,
  output logic [VAL_W-1:0] exp_frames
);
  import shutter_cfg_pkg::*;

  localparam int WORD_W        = VAL_W + 2;
  localparam int CODE_W        = 3;
  localparam int LINES_PER_SEC = LINES_PER_FRAME * FRAME_RATE;
  localparam logic [VAL_W-1:0] FULL_LINES    = VAL_W'(LINES_PER_FRAME);
  localparam logic [VAL_W-1:0] FLICKER_LINES = VAL_W'(LINES_PER_SEC / FLICKER_HZ);
  localparam logic [VAL_W-1:0] ONE_FRAME     = VAL_W'(1);
  localparam logic [WORD_W-1:0] RESET_WORD   = {2'b11, {VAL_W{1'b0}}};

  // reset: asynchronous assert, synchronous release
  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  logic [WORD_W-1:0] ser_word;
  logic              ser_commit;

  shutter_serial_loader #(
    .WORD_W    (WORD_W),
    .RESET_WORD(RESET_WORD)
  ) i_loader (
    .clk       (clk),
    .rst_n     (rst_sync),
    .enable    (~src_parallel),
    .ser_clk   (ser_clk),
    .ser_data  (ser_data),
    .ser_strobe(ser_strobe),
    .word_o    (ser_word),
    .commit_o  (ser_commit)
  );

  logic [CODE_W-1:0] par_code;
  logic [VAL_W-1:0]  tab_lines, tab_frames;
  assign par_code = {ser_data, ser_clk, ser_strobe};

  shutter_speed_table #(
    .VAL_W          (VAL_W),
    .CODE_W         (CODE_W),
    .LINES_PER_FRAME(LINES_PER_FRAME),
    .FRAME_RATE     (FRAME_RATE),
    .MIN_FRAMES     (2)
  ) i_table (
    .code    (par_code),
    .lines_o (tab_lines),
    .frames_o(tab_frames)
  );

  // next-state: pick source, then decode
  logic [1:0]       mb;
  logic [VAL_W-1:0] hi_lines, lo_frames;
  shut_mode_e       mode_d;
  logic [VAL_W-1:0] lines_d, frames_d;

  always_comb begin
    if (src_parallel) begin
      mb        = mode_pins;
      hi_lines  = tab_lines;
      lo_frames = tab_frames;
    end else begin
      mb        = ser_word[WORD_W-1 -: 2];
      hi_lines  = ser_word[VAL_W-1:0];
      lo_frames = ser_word[VAL_W-1:0];
    end
    mode_d = decode_mode(mb);
    case (mode_d)
      SHUT_HIGH:    begin lines_d = hi_lines;      frames_d = ONE_FRAME; end
      SHUT_LOW:     begin lines_d = FULL_LINES;    frames_d = lo_frames; end
      SHUT_FLICKER: begin lines_d = FLICKER_LINES; frames_d = ONE_FRAME; end
      default:      begin lines_d = FULL_LINES;    frames_d = ONE_FRAME; end
    endcase
  end

  shut_mode_e       mode_q;
  logic [VAL_W-1:0] lines_q, frames_q;

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      mode_q   <= SHUT_OFF;
      lines_q  <= FULL_LINES;
      frames_q <= ONE_FRAME;
    end else begin
      mode_q   <= mode_d;
      lines_q  <= lines_d;
      frames_q <= frames_d;
    end
  end

  assign exp_mode   = mode_q;
  assign exp_lines  = lines_q;
  assign exp_frames = frames_q;

  // R7: parallel off selection seen one cycle later
  p_par_off_r7: assert property (@(posedge clk) disable iff (!rst_sync)
    (src_parallel && mode_pins == 2'b11) |=> (exp_mode == 2'd0 && exp_lines == FULL_LINES));

  // R3: low-speed always reports a full frame of lines
  p_low_full_lines_r3: assert property (@(posedge clk) disable iff (!rst_sync)
    (exp_mode == 2'd3) |-> (exp_lines == FULL_LINES));

  // R3: frame count is one outside low-speed
  p_one_frame_r3: assert property (@(posedge clk) disable iff (!rst_sync)
    (exp_mode != 2'd3) |-> (exp_frames == ONE_FRAME));

  // R6: in serial mode without a commit the outputs hold
  p_serial_hold_r6: assert property (@(posedge clk) disable iff (!rst_sync)
    (!src_parallel && $past(!src_parallel) && !$past(ser_commit))
      |=> ($stable(exp_mode) && $stable(exp_lines) && $stable(exp_frames)));

endmodule

// File: tb/test_shutter_setting_reg.sv
module test_shutter_setting_reg;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       src_parallel;
  logic       ser_clk, ser_data, ser_strobe;
  logic [1:0] mode_pins;
  logic [1:0] exp_mode;
  logic [9:0] exp_lines, exp_frames;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  shutter_setting_reg i_shutter_setting_reg (
    .clk(clk), .rst_n(rst_n), .src_parallel(src_parallel),
    .ser_clk(ser_clk), .ser_data(ser_data), .ser_strobe(ser_strobe),
    .mode_pins(mode_pins), .exp_mode(exp_mode),
    .exp_lines(exp_lines), .exp_frames(exp_frames)
  );

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [1:0] m,
                       input logic [9:0] l, input logic [9:0] f);
    n_checks++;
    if (exp_mode !== m || exp_lines !== l || exp_frames !== f) begin
      n_fail++;
      $display("FAIL %s: got mode=%0d lines=%0d frames=%0d, expected mode=%0d lines=%0d frames=%0d",
               req, exp_mode, exp_lines, exp_frames, m, l, f);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(5);
  endtask

  task automatic shift_bits(input logic [15:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      ser_data = w[i];
      wait_cyc(1);
      ser_clk = 1'b1;
      wait_cyc(2);
      ser_clk = 1'b0;
      wait_cyc(1);
    end
    ser_data = 1'b0;
  endtask

  task automatic pulse_strobe();
    ser_strobe = 1'b1;
    wait_cyc(2);
    ser_strobe = 1'b0;
    wait_cyc(3);
  endtask

  task automatic load_word(input logic [1:0] mb, input logic [9:0] v);
    shift_bits({4'b0, mb, v}, 12);
    pulse_strobe();
  endtask

  task automatic t_reset_state();
    do_reset();
    check("R1 reset state", 2'd0, 10'd525, 10'd1);
  endtask

  task automatic t_serial_modes();
    load_word(2'b01, 10'd100);
    check("R2 R3 serial high-speed", 2'd2, 10'd100, 10'd1);
    load_word(2'b10, 10'd5);
    check("R3 serial low-speed", 2'd3, 10'd525, 10'd5);
    load_word(2'b11, 10'd77);
    check("R3 serial off", 2'd0, 10'd525, 10'd1);
    load_word(2'b00, 10'd12);
    check("R3 serial flickerless", 2'd1, 10'd315, 10'd1);
    load_word(2'b01, 10'd2);
    check("R2 serial low boundary", 2'd2, 10'd2, 10'd1);
  endtask

  task automatic t_strobe_no_bits();
    load_word(2'b10, 10'd1022);
    check("R3 serial frames max", 2'd3, 10'd525, 10'd1022);
    pulse_strobe();
    check("R4 strobe with no bits", 2'd3, 10'd525, 10'd1022);
  endtask

  task automatic t_overlong();
    // 3 junk bits, then mode 01 and value 523
    shift_bits({1'b0, 3'b101, 2'b01, 10'd523}, 15);
    pulse_strobe();
    check("R5 last 12 bits kept", 2'd2, 10'd523, 10'd1);
  endtask

  task automatic t_mode_pins_ignored();
    for (int k = 0; k < 4; k++) begin
      mode_pins = 2'(k);
      wait_cyc(3);
      check("R6 mode pins ignored in serial", 2'd2, 10'd523, 10'd1);
    end
  endtask

  task automatic t_parallel();
    logic [9:0] hs [8];
    hs = '{10'd1, 10'd3, 10'd7, 10'd15, 10'd31, 10'd63, 10'd126, 10'd262};
    src_parallel = 1'b1;
    mode_pins = 2'b11;
    wait_cyc(3);
    check("R7 parallel off", 2'd0, 10'd525, 10'd1);
    mode_pins = 2'b00;
    wait_cyc(3);
    check("R7 parallel flickerless", 2'd1, 10'd315, 10'd1);
    for (int c = 0; c < 8; c++) begin
      mode_pins = 2'b01;
      {ser_data, ser_clk, ser_strobe} = 3'(c);
      wait_cyc(3);
      check("R8 parallel high-speed table", 2'd2, hs[c], 10'd1);
      mode_pins = 2'b10;
      wait_cyc(3);
      check("R9 parallel low-speed table", 2'd3, 10'd525, 10'(9 - c));
    end
    {ser_data, ser_clk, ser_strobe} = 3'b000;
    wait_cyc(3);
    src_parallel = 1'b0;
    wait_cyc(3);
    check("R10 serial word kept across parallel", 2'd2, 10'd523, 10'd1);
  endtask

  task automatic t_reset_clears();
    load_word(2'b10, 10'd40);
    check("R2 load before reset", 2'd3, 10'd525, 10'd40);
    do_reset();
    check("R11 reset clears serial word", 2'd0, 10'd525, 10'd1);
  endtask

  initial begin
    rst_n = 1'b0;
    src_parallel = 1'b0;
    ser_clk = 1'b0;
    ser_data = 1'b0;
    ser_strobe = 1'b0;
    mode_pins = 2'b00;
    t_reset_state();
    t_serial_modes();
    t_strobe_no_bits();
    t_overlong();
    t_mode_pins_ignored();
    t_parallel();
    t_reset_clears();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 200000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule